// File: doc/BRIEF.md
# Register Alias Table with Readiness Tracking

This block keeps, for each of eight logical registers, a record of which in-flight result will supply its next value. The record is a 5-bit physical tag pointing at one of 24 reorder-buffer slots, together with a ready flag. A register that has no in-flight producer is marked as living in the architectural register file. In that state it is always ready and reports a tag of zero.

When an instruction issues, the block looks up both of its source registers and returns a tag, an architectural flag and a ready flag for each. In the same clock edge it binds the destination register to the newly allocated tag and marks it not ready. Three writeback tag buses are compared in parallel against every mapped entry, and any entry that matches is woken. A retiring tag is compared the same way, and every matching entry returns to the architectural file. The block does not choose tags and holds no data values.

Top module: `regAliasTable`

## Requirements
- R1: A synchronous active-high reset puts every register in the architectural state. A lookup of any register then returns arch=1, ready=1 and tag=0. An architectural register always reads tag 0.
- R2: With issueValid=1, the register named by issueDst reads, from the next cycle, tag=issueTag, arch=0 and ready=0.
- R3: Source lookups are combinational and reflect the table before the current edge's update. A source equal to the same instruction's destination returns the previous mapping.
- R4: When any writeback bus k is valid (wbValid bit k) and its tag (wbTags bits [5k+4:5k], k = 0 for ALU0, 1 for ALU1, 2 for memory) equals the tag of a mapped entry, that entry reads ready=1 from the next cycle. Every matching entry is set.
- R5: A mapped source whose tag matches a valid writeback tag in the same cycle reads ready=1 at once (bypass).
- R6: With retireValid=1, every mapped entry whose tag equals retireTag reads arch=1, ready=1, tag=0 from the next cycle.
- R7: When an issue writes a register in the same cycle that its old tag retires or is written back, the issue wins: the register gets the new tag with ready=0.
- R8: An architectural entry ignores writeback and retire tags, including tag 0, and stays architectural.
- R9: Writeback tags whose valid bit is 0, a retireTag with retireValid=0, and the issueDst and issueTag fields with issueValid=0 change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issueValid | input | 1 | An instruction issues this cycle |
| issueSrc1 | input | 3 | First source logical register |
| issueSrc2 | input | 3 | Second source logical register |
| issueDst | input | 3 | Destination logical register |
| issueTag | input | 5 | Newly allocated physical tag for the destination |
| wbValid | input | 3 | Valid bit per writeback bus (ALU0, ALU1, memory) |
| wbTags | input | 15 | Three packed writeback tags, bus k at bits [5k+4:5k] |
| retireValid | input | 1 | A tag retires this cycle |
| retireTag | input | 5 | Retiring physical tag |
| src1Tag | output | 5 | Physical tag of source 1 (0 when architectural) |
| src1Arch | output | 1 | Source 1 reads the architectural register file |
| src1Ready | output | 1 | Source 1 value is available |
| src2Tag | output | 5 | Physical tag of source 2 (0 when architectural) |
| src2Arch | output | 1 | Source 2 reads the architectural register file |
| src2Ready | output | 1 | Source 2 value is available |

## Verification
Random traffic draws writeback and retire tags mostly from the tags currently mapped. This exercises real matches against several entries, and separates parallel wake-up from a single-entry compare. Directed cases cover issue racing retire and writeback on the same register, two registers that share one tag, a source that equals its own destination, and tag 0 presented while registers are architectural. These cases separate update priority, the before-update read, the retire fan-out and the masking of architectural entries. Cycles with valid bits low but matching tags on the buses confirm that the qualifiers gate every change.

// File: rtl/ratPkg.sv
package ratPkg;
  // Per-entry update strobes, control to datapath.
  typedef struct packed {
    logic load;   // bind to issue tag
    logic free;   // return to architectural file
    logic wake;   // mark value ready
  } slotCmd_t;
endpackage

// File: rtl/ratTable.sv
module ratTable
  import ratPkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int TAG_W    = 5,
  parameter int NUM_WB   = 3,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  slotCmd_t [NUM_REGS-1:0]        cmd,
  input  logic [TAG_W-1:0]               issueTag,
  input  logic [NUM_WB-1:0]              wbValid,
  input  logic [NUM_WB-1:0][TAG_W-1:0]   wbTagArr,
  input  logic                           retireValid,
  input  logic [TAG_W-1:0]               retireTag,
  input  logic [1:0][REG_W-1:0]          srcIdx,
  output logic [NUM_REGS-1:0]            wbHit,
  output logic [NUM_REGS-1:0]            retHit,
  output logic [1:0][TAG_W-1:0]          srcTag,
  output logic [1:0]                     srcArch,
  output logic [1:0]                     srcReady
);
  logic [TAG_W-1:0]    tagQ [NUM_REGS];
  logic [NUM_REGS-1:0] archQ;
  logic [NUM_REGS-1:0] rdyQ;

  function automatic logic busMatch(input logic [TAG_W-1:0] t,
                                    input logic [NUM_WB-1:0] v,
                                    input logic [NUM_WB-1:0][TAG_W-1:0] bus);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NUM_WB; k++) hit |= v[k] && (bus[k] == t);
    return hit;
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    assign wbHit[i]  = !archQ[i] && busMatch(tagQ[i], wbValid, wbTagArr);
    assign retHit[i] = retireValid && !archQ[i] && (tagQ[i] == retireTag);

    always_ff @(posedge clk) begin
      if (rst) begin
        tagQ[i]  <= '0;
        archQ[i] <= 1'b1;
        rdyQ[i]  <= 1'b1;
      end else if (cmd[i].load) begin
        tagQ[i]  <= issueTag;
        archQ[i] <= 1'b0;
        rdyQ[i]  <= 1'b0;
      end else if (cmd[i].free) begin
        tagQ[i]  <= '0;
        archQ[i] <= 1'b1;
        rdyQ[i]  <= 1'b1;
      end else if (cmd[i].wake) begin
        rdyQ[i]  <= 1'b1;
      end
    end

    // R2: a load leaves the slot mapped to the issued tag, not ready
    a_r2_load_binds: assert property (@(posedge clk) disable iff (rst)
      cmd[i].load |=> (tagQ[i] == $past(issueTag)) && !archQ[i] && !rdyQ[i]);
    // R6: a free returns the slot to the architectural file
    a_r6_free_restores: assert property (@(posedge clk) disable iff (rst)
      cmd[i].free |=> archQ[i] && rdyQ[i] && (tagQ[i] == '0));
    // R4: a wake keeps the tag and sets ready
    a_r4_wake_sets: assert property (@(posedge clk) disable iff (rst)
      cmd[i].wake |=> rdyQ[i] && !archQ[i] && $stable(tagQ[i]));
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    always_comb begin
      srcArch[s]  = archQ[srcIdx[s]];
      srcTag[s]   = archQ[srcIdx[s]] ? '0 : tagQ[srcIdx[s]];
      srcReady[s] = rdyQ[srcIdx[s]] || wbHit[srcIdx[s]];
    end
    // R1: an architectural source is always ready with tag 0
    a_r1_arch_ready: assert property (@(posedge clk) disable iff (rst)
      srcArch[s] |-> srcReady[s] && (srcTag[s] == '0));
  end
endmodule

// File: rtl/ratCtrl.sv
module ratCtrl
  import ratPkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issueValid,
  input  logic [REG_W-1:0]        issueDst,
  input  logic [NUM_REGS-1:0]     wbHit,
  input  logic [NUM_REGS-1:0]     retHit,
  output slotCmd_t [NUM_REGS-1:0] cmd
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmd
    always_comb begin
      cmd[i].load = issueValid && (issueDst == REG_W'(i));
      cmd[i].free = retHit[i] && !cmd[i].load;
      cmd[i].wake = wbHit[i] && !retHit[i] && !cmd[i].load;
    end
  end

  // R7: the issued destination is never freed in its own issue cycle
  a_r7_issue_wins: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> !cmd[issueDst].free && !cmd[issueDst].wake);
endmodule

// File: rtl/regAliasTable.sv
module regAliasTable
  import ratPkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int ROB_ENTRIES = 24,
  parameter int NUM_WB      = 3,
  parameter int TAG_W       = $clog2(ROB_ENTRIES),
  parameter int REG_W       = $clog2(NUM_REGS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issueValid,
  input  logic [REG_W-1:0]        issueSrc1,
  input  logic [REG_W-1:0]        issueSrc2,
  input  logic [REG_W-1:0]        issueDst,
  input  logic [TAG_W-1:0]        issueTag,
  input  logic [NUM_WB-1:0]       wbValid,
  input  logic [NUM_WB*TAG_W-1:0] wbTags,
  input  logic                    retireValid,
  input  logic [TAG_W-1:0]        retireTag,
  output logic [TAG_W-1:0]        src1Tag,
  output logic                    src1Arch,
  output logic                    src1Ready,
  output logic [TAG_W-1:0]        src2Tag,
  output logic                    src2Arch,
  output logic                    src2Ready
);
  slotCmd_t [NUM_REGS-1:0]      cmd;
  logic [NUM_REGS-1:0]          wbHit, retHit;
  logic [NUM_WB-1:0][TAG_W-1:0] wbTagArr;
  logic [1:0][REG_W-1:0]        srcIdx;
  logic [1:0][TAG_W-1:0]        srcTag;
  logic [1:0]                   srcArch, srcReady;

  assign wbTagArr = wbTags;
  assign srcIdx   = {issueSrc2, issueSrc1};

  ratCtrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueDst(issueDst),
    .wbHit(wbHit), .retHit(retHit), .cmd(cmd));

  ratTable #(.NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .NUM_WB(NUM_WB)) u_table (
    .clk(clk), .rst(rst), .cmd(cmd), .issueTag(issueTag),
    .wbValid(wbValid), .wbTagArr(wbTagArr),
    .retireValid(retireValid), .retireTag(retireTag), .srcIdx(srcIdx),
    .wbHit(wbHit), .retHit(retHit),
    .srcTag(srcTag), .srcArch(srcArch), .srcReady(srcReady));

  assign src1Tag   = srcTag[0];
  assign src1Arch  = srcArch[0];
  assign src1Ready = srcReady[0];
  assign src2Tag   = srcTag[1];
  assign src2Arch  = srcArch[1];
  assign src2Ready = srcReady[1];
endmodule

// File: tb/regAliasTable_test.sv
`timescale 1ns/1ps
module regAliasTable_test;
  logic clk = 0, rst = 1;
  logic issueValid = 0;
  logic [2:0] issueSrc1 = 0, issueSrc2 = 0, issueDst = 0;
  logic [4:0] issueTag = 0, retireTag = 0;
  logic [2:0] wbValid = 0;
  logic [14:0] wbTags = 0;
  logic retireValid = 0;
  logic [4:0] src1Tag, src2Tag;
  logic src1Arch, src1Ready, src2Arch, src2Ready;
  int total = 0, bad = 0;
  bit finished = 0;

  logic [4:0] mTag [8];
  bit mArch [8], mRdy [8];

  always #2 clk = ~clk;

  regAliasTable uut (.*);

  function automatic bit wbMatch(input logic [4:0] t);
    bit h = 0;
    for (int k = 0; k < 3; k++) if (wbValid[k] && wbTags[5*k +: 5] == t) h = 1;
    return h;
  endfunction

  task automatic checkSrc(input string req, input int which, input logic [2:0] r,
                          input logic [4:0] aTag, input logic aArch, input logic aRdy);
    logic [4:0] eTag = mArch[r] ? 5'd0 : mTag[r];
    bit eArch = mArch[r];
    bit eRdy  = mArch[r] || mRdy[r] || wbMatch(mTag[r]);
    total++;
    if (aTag !== eTag || aArch !== eArch || aRdy !== eRdy) begin
      bad++;
      $display("FAIL %s src%0d reg=%0d tag/arch/ready actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
               req, which, r, aTag, aArch, aRdy, eTag, eArch, eRdy);
    end
  endtask

  // Inputs are set; check lookups, take the edge, advance the model.
  task automatic step(input string req);
    #0.5;
    checkSrc(req, 1, issueSrc1, src1Tag, src1Arch, src1Ready);
    checkSrc(req, 2, issueSrc2, src2Tag, src2Arch, src2Ready);
    @(posedge clk);
    for (int r = 0; r < 8; r++) begin
      if (issueValid && issueDst == r) begin
        mTag[r] = issueTag; mArch[r] = 0; mRdy[r] = 0;
      end else if (!mArch[r]) begin
        if (retireValid && retireTag == mTag[r]) begin
          mTag[r] = 0; mArch[r] = 1; mRdy[r] = 1;
        end else if (wbMatch(mTag[r])) mRdy[r] = 1;
      end
    end
    @(negedge clk);
    issueValid = 0; wbValid = 0; retireValid = 0;
  endtask

  task automatic look(input logic [2:0] a, input logic [2:0] b);
    issueSrc1 = a; issueSrc2 = b;
  endtask

  task automatic doIssue(input logic [2:0] d, input logic [4:0] t);
    issueValid = 1; issueDst = d; issueTag = t;
  endtask

  function automatic logic [4:0] pickTag();
    int r = $urandom % 8;
    if (($urandom % 4) != 0 && !mArch[r]) return mTag[r];
    return 5'($urandom % 24);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin mTag[r] = 0; mArch[r] = 1; mRdy[r] = 1; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: every register architectural after reset
    for (int r = 0; r < 8; r += 2) begin look(3'(r), 3'(r + 1)); step("R1"); end
    // R2: issue binds tag 7 to r3
    doIssue(3, 7); look(3, 3); step("R2");
    look(3, 0); step("R2");
    // R3: source equal to destination reads old mapping
    doIssue(3, 9); look(3, 1); step("R3");
    look(3, 3); step("R3");
    // R5: bypass on bus 2 (memory)
    wbValid = 3'b100; wbTags = {5'd9, 5'd1, 5'd2}; look(3, 3); step("R5");
    // R4: ready persists
    look(3, 3); step("R4");
    // R6: two registers sharing tag 11 both retire
    doIssue(5, 11); step("R6");
    doIssue(6, 11); step("R6");
    look(5, 6); step("R6");
    retireValid = 1; retireTag = 11; look(5, 6); step("R6");
    look(5, 6); step("R6");
    // R7: issue wins over retire and writeback of old tag
    doIssue(2, 4); step("R7");
    doIssue(2, 12); retireValid = 1; retireTag = 4;
    wbValid = 3'b001; wbTags = {5'd0, 5'd0, 5'd4}; look(2, 2); step("R7");
    look(2, 2); step("R7");
    // R8: tag 0 on wb and retire while r0 is architectural
    wbValid = 3'b111; wbTags = 0; retireValid = 1; retireTag = 0; look(0, 0); step("R8");
    look(0, 7); step("R8");
    // R9: qualifiers low with matching fields
    doIssue(1, 20); step("R9");
    issueDst = 1; issueTag = 21; wbTags = {3{5'd20}}; retireTag = 20; look(1, 1); step("R9");
    look(1, 1); step("R9");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      issueValid = ($urandom % 2) == 1;
      issueDst = 3'($urandom); issueTag = 5'($urandom % 24);
      wbValid = 3'($urandom);
      wbTags = {pickTag(), pickTag(), pickTag()};
      retireValid = ($urandom % 3) == 0; retireTag = pickTag();
      look(3'($urandom), 3'($urandom));
      step("R4");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule